// File: doc/BRIEF.md
# Programmable Envelope Generator

This block produces a 5-bit amplitude level that moves through time in one of several patterns. The channel level selectors of a sound generator read this level when a channel is set to variable amplitude. The pattern is a ramp of 32 steps. The ramp can rise or fall. Once the first ramp ends, the pattern does one of four things: it drops to silence, repeats as a sawtooth, reverses direction every ramp to form a triangle, or freezes at one end.

The step rate comes from a 16-bit period value. The period is counted in enabled master-clock cycles, so one step lasts eight times the period. A 4-bit shape code selects the pattern. A restart pulse is raised when software writes the shape register. The block takes the shape code on that pulse, clears its step prescaler and starts the pattern again from the first step.

Top module: `envgen`

## Requirements
- R1: After reset, `level_o` is 0 and stays 0, whatever the clock enable does, until the first restart pulse.
- R2: On the clock edge that samples `restart_i` high, the step prescaler is cleared and `level_o` becomes 0 when shape bit 2 (attack) is 1, or 31 when it is 0.
- R3: Each level lasts exactly 8·P enabled cycles, where P is `period_i`. A period of 0 is treated as 1.
- R4: Clock edges with `tick_en_i` low neither advance the prescaler nor change `level_o`.
- R5: During the first ramp after a restart, the level moves by one per step. It rises 0..31 when attack is 1 and falls 31..0 when attack is 0.
- R6: When shape bit 3 (continue) is 0, the level becomes 0 after the first ramp and stays 0.
- R7: When continue is 1, bit 0 (hold) is 0 and bit 1 (alternate) is 0, every later ramp repeats the direction of the first one.
- R8: When continue is 1, hold is 0 and alternate is 1, the direction reverses at the start of every ramp.
- R9: When continue and hold are both 1, the level freezes after the first ramp. It stays at that ramp's end value when alternate is 0, and at the opposite end value when alternate is 1.
- R10: The shape code is taken only on a restart pulse. Changing `shape_i` at any other time has no effect on `level_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Master clock enable; one enabled cycle is one master cycle |
| period_i | input | 16 | Envelope period P; one step lasts 8·P enabled cycles |
| shape_i | input | 4 | Shape code: bit 3 continue, bit 2 attack, bit 1 alternate, bit 0 hold |
| restart_i | input | 1 | Single-cycle pulse on a shape register write |
| level_o | output | 5 | Current envelope level |

## Verification
The assertions assume that `restart_i` is a clean synchronous pulse. They also assume that `period_i` does not fall below the prescaler's current count, so that each step is one continuous count. They judge the level only by its steps and its stability, never by absolute timing. The bench keeps `period_i` fixed between restarts and always raises the restart on a falling edge. It sweeps all sixteen shape codes over four full ramps at the smallest period. It also covers a zero period, a gated enable pattern and a restart in the middle of a step, and it changes `shape_i` after each restart. Every level is predicted from the step index with arithmetic.

// File: rtl/envgen_pkg.sv
package envgen_pkg;

    localparam int unsigned LVL_W   = 5;
    localparam int unsigned SHAPE_W = 4;
    localparam logic [LVL_W-1:0] LVL_TOP = '1;

    // Shape code fields; bit order follows the register bit order
    typedef struct packed {
        logic cont;
        logic att;
        logic alt;
        logic hold;
    } shape_t;

    typedef struct packed {
        shape_t           shape;
        logic [LVL_W-1:0] step;
        logic             rising;
        logic             frozen;
        logic [LVL_W-1:0] frozen_lvl;
    } stepper_state_t;

endpackage

// File: rtl/envgen_prescaler.sv
module envgen_prescaler #(
    parameter int unsigned PER_W = 16,
    parameter int unsigned SUB_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_i,
    input  logic             clear_i,
    input  logic [PER_W-1:0] period_i,
    output logic             step_o
);
    localparam int unsigned CNT_W = PER_W + SUB_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t       st_d, st_q;
    logic [PER_W-1:0] eff_period;
    logic [CNT_W-1:0] last_cnt;
    logic             at_end;

    always_comb begin
        // Zero period behaves like one
        eff_period = (period_i == '0) ? {{(PER_W-1){1'b0}}, 1'b1} : period_i;
        last_cnt   = {eff_period, {SUB_W{1'b0}}} - {{(CNT_W-1){1'b0}}, 1'b1};
        at_end     = (st_q.cnt >= last_cnt);
        step_o     = ce_i && at_end && !clear_i;

        st_d = st_q;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (ce_i) begin
            st_d.cnt = at_end ? '0 : st_q.cnt + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/envgen_stepper.sv
module envgen_stepper
    import envgen_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart_i,
    input  logic [SHAPE_W-1:0]   shape_i,
    input  logic                 step_i,
    output logic [LVL_W-1:0]     level_o
);
    stepper_state_t st_d, st_q;
    shape_t         new_shape;
    logic           ramp_done;

    always_comb begin
        new_shape = shape_t'(shape_i);
        ramp_done = (st_q.step == LVL_TOP);

        st_d = st_q;
        if (restart_i) begin
            st_d.shape      = new_shape;
            st_d.step       = '0;
            st_d.rising     = new_shape.att;
            st_d.frozen     = 1'b0;
            st_d.frozen_lvl = '0;
        end else if (step_i && !st_q.frozen) begin
            if (!ramp_done) begin
                st_d.step = st_q.step + {{(LVL_W-1){1'b0}}, 1'b1};
            end else if (!st_q.shape.cont) begin
                st_d.frozen     = 1'b1;
                st_d.frozen_lvl = '0;
            end else if (st_q.shape.hold) begin
                // End value of this ramp, or the other end when alternating
                st_d.frozen     = 1'b1;
                st_d.frozen_lvl = (st_q.rising ^ st_q.shape.alt) ? LVL_TOP : '0;
            end else begin
                st_d.step   = '0;
                st_d.rising = st_q.rising ^ st_q.shape.alt;
            end
        end

        if (st_q.frozen) begin
            level_o = st_q.frozen_lvl;
        end else if (st_q.rising) begin
            level_o = st_q.step;
        end else begin
            level_o = LVL_TOP - st_q.step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.frozen     <= 1'b1;
            st_q.frozen_lvl <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/envgen.sv
module envgen
    import envgen_pkg::*;
#(
    parameter int unsigned PER_W = 16,
    parameter int unsigned SUB_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en_i,
    input  logic [PER_W-1:0]   period_i,
    input  logic [SHAPE_W-1:0] shape_i,
    input  logic               restart_i,
    output logic [LVL_W-1:0]   level_o
);
    logic step_pulse;

    envgen_prescaler #(
        .PER_W (PER_W),
        .SUB_W (SUB_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_i     (tick_en_i),
        .clear_i  (restart_i),
        .period_i (period_i),
        .step_o   (step_pulse)
    );

    envgen_stepper u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart_i),
        .shape_i   (shape_i),
        .step_i    (step_pulse),
        .level_o   (level_o)
    );

endmodule

// File: rtl/envgen_checker.sv
module envgen_checker
    import envgen_pkg::*;
#(
    parameter int unsigned PER_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_en_i,
    input logic [PER_W-1:0]   period_i,
    input logic [SHAPE_W-1:0] shape_i,
    input logic               restart_i,
    input logic [LVL_W-1:0]   level_o
);
    logic started_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started_q <= 1'b0;
        end else if (restart_i) begin
            started_q <= 1'b1;
        end
    end

    // R1: silent from reset until the first restart
    a_r1_silent_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !started_q |-> level_o == '0);

    // R2: first level after a restart depends on the attack bit
    a_r2_restart_start: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> level_o == ($past(shape_i[2]) ? '0 : LVL_TOP));

    // R4: no enable, no movement
    a_r4_gated_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en_i && !restart_i) |=> $stable(level_o));

    // R5: without restart the level moves by one or jumps to an end value
    a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_i |=> ($stable(level_o)
                        || level_o == $past(level_o) + 5'd1
                        || level_o == $past(level_o) - 5'd1
                        || level_o == '0
                        || level_o == LVL_TOP));

endmodule

bind envgen envgen_checker #(.PER_W(PER_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en_i (tick_en_i),
    .period_i  (period_i),
    .shape_i   (shape_i),
    .restart_i (restart_i),
    .level_o   (level_o)
);

// File: tb/envgen_test.sv
module envgen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en_i = 1'b0;
    logic [15:0] period_i = '0;
    logic [3:0]  shape_i = '0;
    logic        restart_i = 1'b0;
    logic [4:0]  level_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    envgen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en_i (tick_en_i),
        .period_i  (period_i),
        .shape_i   (shape_i),
        .restart_i (restart_i),
        .level_o   (level_o)
    );

    always #5 clk = ~clk;

    function automatic int exp_lvl(bit [3:0] s, int n);
        int k, r;
        bit up;
        if (n < 32) return s[2] ? n : 31 - n;
        if (!s[3]) return 0;
        if (s[0]) return (s[2] ^ s[1]) ? 31 : 0;
        k  = n / 32;
        r  = n % 32;
        up = s[2] ^ (s[1] & k[0]);
        return up ? r : 31 - r;
    endfunction

    function automatic string tag_of(bit [3:0] s, int n);
        if (n == 0) return "R2";
        if (n < 32) return "R5";
        if (!s[3]) return "R6";
        if (s[0]) return "R9";
        if (s[1]) return "R8";
        return "R7";
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: level actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Restart with shape s and period ep, then follow 'edges' enabled edges.
    // gap > 0 keeps the enable high on one edge in every gap+1.
    task automatic run(bit [3:0] s, int ep, int edges, int gap, string extra);
        int len, e, c;
        bit ce_now;
        len = 8 * ((ep == 0) ? 1 : ep);
        @(negedge clk);
        shape_i   = s;
        period_i  = ep[15:0];
        restart_i = 1'b1;
        tick_en_i = 1'b1;
        @(negedge clk);
        restart_i = 1'b0;
        shape_i   = ~s; // R10: must be ignored
        e = 0;
        c = 0;
        while (e < edges) begin
            check({tag_of(s, e / len), extra}, int'(level_o), exp_lvl(s, e / len));
            ce_now    = (gap == 0) || ((c % (gap + 1)) == 0);
            tick_en_i = ce_now;
            @(negedge clk);
            if (ce_now) e++;
            c++;
        end
    endtask

    initial begin
        // R1: reset state and silence until restart
        repeat (3) @(negedge clk);
        check("R1", int'(level_o), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 40; i++) begin
            tick_en_i = i[0];
            period_i  = 16'd1;
            shape_i   = i[3:0];
            @(negedge clk);
            check("R1", int'(level_o), 0);
        end

        // All shapes, four ramps each, smallest period (R3 R5..R10)
        for (int s = 0; s < 16; s++) begin
            run(s[3:0], 1, 128 * 8, 0, "+R10");
        end

        // R3: zero period acts as one; longer period
        run(4'b1110, 0, 40 * 8, 0, "+R3");
        run(4'b1000, 3, 36 * 24, 0, "+R3");

        // R4: gated enable stretches steps
        run(4'b1010, 2, 40 * 16, 1, "+R4");
        run(4'b1101, 1, 36 * 8, 2, "+R4");

        // R2: restart in the middle of a step clears the prescaler
        run(4'b1100, 2, 5 * 16 + 7, 0, "+R2");
        run(4'b0000, 2, 34 * 16, 0, "+R2");
        run(4'b1011, 1, 3 * 8 + 5, 0, "+R2");
        run(4'b0111, 1, 34 * 8, 0, "+R2");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule